// File: doc/BRIEF.md
# Region Memory Access Guard

The guard sits beside a processor's load, store and instruction-fetch path and judges every access against eight programmable address windows. Each window has a power-of-two size, a base aligned to that size, and three attribute bits: read-only, no-execute and supervisor-only. A window written with its enable bit low is ignored. When windows overlap, the one with the highest index decides. An address that falls in no window is allowed only for privileged accesses.

The verdict (`acc_allow` or `acc_deny`) is combinational in the same cycle as the access. The first denied access raises a sticky fault flag, `flt_pending`, which can drive an interrupt line. On that clock edge the guard also stores the offending address and a cause code. Both stay frozen until software pulses `flt_clear`. Software sets up windows through a one-cycle write port, and each write applies from the next clock edge on.

Top module: `region_guard`

## Requirements
- R1: Asserting `cfg_we` for one cycle loads window `cfg_idx` with the `cfg_*` fields at that clock edge. An access made in the same cycle as the write is still judged against the old window contents.
- R2: Window i covers 2^(c+1) bytes, where c is its 5-bit size code. The low c+1 bits of its base are ignored. Codes 0 to 3 act as code 4, which gives 32 bytes. Code 31 covers the whole 4 GB space.
- R3: A window whose enable bit is 0 never matches any address.
- R4: When several enabled windows contain the address, only the highest-numbered one supplies the attributes.
- R5: A write (`acc_kind`=1) into a read-only window is denied, with cause 1. Reads and fetches are not affected by the read-only bit.
- R6: An instruction fetch (`acc_kind`=2) into a no-execute window is denied, with cause 2. Reads and writes are not affected by the no-execute bit.
- R7: An unprivileged access (`acc_priv`=0) to a supervisor-only window is denied, with cause 3. This test takes precedence over R5 and R6. Privileged accesses to such a window follow R5 and R6.
- R8: An access that matches no window is allowed when privileged. It is denied when unprivileged, with a cause equal to its kind: read 0, write 1, fetch 2. Kind code 3 is treated as a read.
- R9: While `acc_valid` is high, exactly one of `acc_allow` and `acc_deny` is high in that same cycle. While `acc_valid` is low, both are low.
- R10: On a denied access with no fault pending, the next clock edge sets `flt_pending`. The same edge loads `flt_addr` with the access address and `flt_cause` with the cause.
- R11: While a fault is pending, later denials leave the address and cause unchanged. `flt_clear` drops `flt_pending` at the next edge and takes priority over a denial in the same cycle.
- R12: After reset, every window is disabled, `flt_pending` is 0, and `flt_addr` and `flt_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | 3 | Window index to write |
| cfg_base | input | 32 | Window base address |
| cfg_size | input | 5 | Size code, log2(bytes) minus 1 |
| cfg_ro | input | 1 | Read-only attribute |
| cfg_xn | input | 1 | No-execute attribute |
| cfg_sup | input | 1 | Supervisor-only attribute |
| cfg_en | input | 1 | Window enable |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_allow | output | 1 | Access permitted |
| acc_deny | output | 1 | Access refused |
| flt_clear | input | 1 | Clear the pending fault |
| flt_pending | output | 1 | Sticky fault flag |
| flt_addr | output | 32 | Address of the first fault |
| flt_cause | output | 2 | Cause: 0 read, 1 write, 2 fetch, 3 privilege |

## Verification
Directed accesses sit just inside and just outside window edges, at the minimum 32-byte size, at a code below 4 and at the whole-space code. These separate faults in the mask arithmetic from faults in the base comparison. Nested windows are written in both index orders, which shows whether the winner follows the index or the order of writes. Each attribute bit is tried with every access kind, at both privilege levels, to separate the precedence of the three checks. A random phase mixes window writes, accesses and clears, and a behavioural model that divides addresses by the window span judges every cycle.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CAUSE_READ  = 2'd0,
    CAUSE_WRITE = 2'd1,
    CAUSE_FETCH = 2'd2,
    CAUSE_PRIV  = 2'd3
  } cause_e;

  function automatic cause_e kind_cause(input kind_e k);
    case (k)
      KIND_WRITE: return CAUSE_WRITE;
      KIND_FETCH: return CAUSE_FETCH;
      default:    return CAUSE_READ;
    endcase
  endfunction
endpackage

// File: rtl/rg_region_bank.sv
module rg_region_bank #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG),
  localparam int SZW = $clog2(AW)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [IW-1:0]             cfg_idx,
  input  logic [AW-1:0]             cfg_base,
  input  logic [SZW-1:0]            cfg_size,
  input  logic                      cfg_ro,
  input  logic                      cfg_xn,
  input  logic                      cfg_sup,
  input  logic                      cfg_en,
  output logic [NREG-1:0]           win_en,
  output logic [NREG-1:0]           win_ro,
  output logic [NREG-1:0]           win_xn,
  output logic [NREG-1:0]           win_sup,
  output logic [NREG-1:0][SZW-1:0]  win_size,
  output logic [NREG-1:0][AW-1:0]   win_base
);
  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic sel;
    assign sel = cfg_we && (cfg_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_en[g]   <= 1'b0;
        win_ro[g]   <= 1'b0;
        win_xn[g]   <= 1'b0;
        win_sup[g]  <= 1'b0;
        win_size[g] <= '0;
        win_base[g] <= '0;
      end else if (sel) begin
        win_en[g]   <= cfg_en;
        win_ro[g]   <= cfg_ro;
        win_xn[g]   <= cfg_xn;
        win_sup[g]  <= cfg_sup;
        win_size[g] <= cfg_size;
        win_base[g] <= cfg_base;
      end
    end
  end

  // R1
  cfg_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (win_en[$past(cfg_idx)] == $past(cfg_en)) && (win_ro[$past(cfg_idx)] == $past(cfg_ro)));
endmodule

// File: rtl/rg_match.sv
module rg_match #(
  parameter int NREG     = 8,
  parameter int AW       = 32,
  parameter int MIN_CODE = 4,
  localparam int IW      = $clog2(NREG),
  localparam int SZW     = $clog2(AW)
) (
  input  logic [AW-1:0]             addr,
  input  logic [NREG-1:0]           win_en,
  input  logic [NREG-1:0]           win_ro,
  input  logic [NREG-1:0]           win_xn,
  input  logic [NREG-1:0]           win_sup,
  input  logic [NREG-1:0][SZW-1:0]  win_size,
  input  logic [NREG-1:0][AW-1:0]   win_base,
  output logic [NREG-1:0]           hit_vec,
  output logic                      hit_any,
  output logic [IW-1:0]             hit_idx,
  output logic                      hit_ro,
  output logic                      hit_xn,
  output logic                      hit_sup
);
  // Bits of the address that must equal the base for a given size code.
  function automatic logic [AW-1:0] span_mask(input logic [SZW-1:0] code);
    logic [SZW-1:0] c;
    logic [AW:0]    lsb;
    c   = (code < SZW'(MIN_CODE)) ? SZW'(MIN_CODE) : code;
    lsb = {{AW{1'b0}}, 1'b1} << ({1'b0, c} + 1'b1);
    return ~(lsb[AW-1:0] - 1'b1);
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit_vec[g] = win_en[g] && (((addr ^ win_base[g]) & span_mask(win_size[g])) == '0);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign hit_any = |hit_vec;
  assign hit_ro  = hit_any && win_ro[hit_idx];
  assign hit_xn  = hit_any && win_xn[hit_idx];
  assign hit_sup = hit_any && win_sup[hit_idx];
endmodule

// File: rtl/rg_fault_latch.sv
module rg_fault_latch #(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [AW-1:0]    evt_addr,
  input  rg_pkg::cause_e   evt_cause,
  input  logic             clear,
  output logic             pending,
  output logic [AW-1:0]    addr_q,
  output rg_pkg::cause_e   cause_q
);
  logic capture;
  assign capture = evt && !pending && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      addr_q  <= '0;
      cause_q <= rg_pkg::CAUSE_READ;
    end else if (clear) begin
      pending <= 1'b0;
    end else if (capture) begin
      pending <= 1'b1;
      addr_q  <= evt_addr;
      cause_q <= evt_cause;
    end
  end

  // R10
  fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !pending && !clear) |=> pending && (addr_q == $past(evt_addr)) && (cause_q == $past(evt_cause)));
  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clear) |=> pending && $stable(addr_q) && $stable(cause_q));
  // R11
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pending);
endmodule

// File: rtl/region_guard.sv
module region_guard #(
  parameter int NREG     = 8,
  parameter int AW       = 32,
  parameter int MIN_CODE = 4,
  localparam int IW      = $clog2(NREG),
  localparam int SZW     = $clog2(AW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_base,
  input  logic [SZW-1:0]  cfg_size,
  input  logic            cfg_ro,
  input  logic            cfg_xn,
  input  logic            cfg_sup,
  input  logic            cfg_en,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_addr,
  input  logic [1:0]      acc_kind,
  input  logic            acc_priv,
  output logic            acc_allow,
  output logic            acc_deny,
  input  logic            flt_clear,
  output logic            flt_pending,
  output logic [AW-1:0]   flt_addr,
  output logic [1:0]      flt_cause
);
  import rg_pkg::*;

  logic [NREG-1:0]          w_en, w_ro, w_xn, w_sup, hit_vec;
  logic [NREG-1:0][SZW-1:0] w_size;
  logic [NREG-1:0][AW-1:0]  w_base;
  logic                     m_hit, m_ro, m_xn, m_sup;
  logic [IW-1:0]            m_idx;
  kind_e                    kind;
  cause_e                   v_cause, q_cause;
  logic                     v_deny;

  rg_region_bank #(.NREG(NREG), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_ro(cfg_ro), .cfg_xn(cfg_xn),
    .cfg_sup(cfg_sup), .cfg_en(cfg_en),
    .win_en(w_en), .win_ro(w_ro), .win_xn(w_xn), .win_sup(w_sup),
    .win_size(w_size), .win_base(w_base)
  );

  rg_match #(.NREG(NREG), .AW(AW), .MIN_CODE(MIN_CODE)) u_match (
    .addr(acc_addr), .win_en(w_en), .win_ro(w_ro), .win_xn(w_xn), .win_sup(w_sup),
    .win_size(w_size), .win_base(w_base),
    .hit_vec(hit_vec), .hit_any(m_hit), .hit_idx(m_idx),
    .hit_ro(m_ro), .hit_xn(m_xn), .hit_sup(m_sup)
  );

  assign kind = kind_e'(acc_kind);

  // Verdict precedence: no match, supervisor-only, read-only, no-execute.
  always_comb begin
    v_deny  = 1'b0;
    v_cause = kind_cause(kind);
    if (!m_hit) begin
      v_deny = !acc_priv;
    end else if (m_sup && !acc_priv) begin
      v_deny  = 1'b1;
      v_cause = CAUSE_PRIV;
    end else if (kind == KIND_WRITE && m_ro) begin
      v_deny = 1'b1;
    end else if (kind == KIND_FETCH && m_xn) begin
      v_deny = 1'b1;
    end
  end

  assign acc_allow = acc_valid && !v_deny;
  assign acc_deny  = acc_valid && v_deny;

  rg_fault_latch #(.AW(AW)) u_fault (
    .clk(clk), .rst_n(rst_n), .evt(acc_deny), .evt_addr(acc_addr),
    .evt_cause(v_cause), .clear(flt_clear),
    .pending(flt_pending), .addr_q(flt_addr), .cause_q(q_cause)
  );
  assign flt_cause = q_cause;

  // R9
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones({acc_allow, acc_deny}) == 1);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_allow && !acc_deny);
  // R5
  write_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && m_hit && m_ro && kind == KIND_WRITE) |-> acc_deny);
  // R6
  fetch_xn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && m_hit && m_xn && kind == KIND_FETCH) |-> acc_deny);
  // R7
  sup_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && m_hit && m_sup && !acc_priv) |-> acc_deny);
  // R8
  nomatch_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !m_hit && acc_priv) |-> acc_allow);
  // R4
  winner_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_hit |-> hit_vec[m_idx] && ((hit_vec >> m_idx) == {{(NREG-1){1'b0}}, 1'b1}));
endmodule

// File: tb/tb_region_guard.sv
`timescale 1ns/1ps
module tb_region_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_size = '0;
  logic        cfg_ro = 1'b0, cfg_xn = 1'b0, cfg_sup = 1'b0, cfg_en = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_priv = 1'b0;
  logic        acc_allow, acc_deny;
  logic        flt_clear = 1'b0;
  logic        flt_pending;
  logic [31:0] flt_addr;
  logic [1:0]  flt_cause;

  region_guard dut (.*);

  always #4 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    running = 0;
  string cur_req = "R9";

  // reference state
  logic [31:0] mb[8];
  int          mc[8];
  bit          men[8], mro[8], mxn[8], msup[8];
  bit          mpend;
  logic [31:0] maddr;
  int          mcause;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_eval(input logic [31:0] a, input int k, input bit p,
                                   output bit deny, output int cause);
    int w = -1;
    longint unsigned ua = {32'd0, a};
    int kc = (k == 1) ? 1 : (k == 2) ? 2 : 0;
    for (int i = 7; i >= 0; i--) begin
      if (w < 0 && men[i]) begin
        int c = (mc[i] < 4) ? 4 : mc[i];
        longint unsigned span = 64'd1 << (c + 1);
        longint unsigned ub = {32'd0, mb[i]};
        if (ua / span == ub / span) w = i;
      end
    end
    deny = 0;
    cause = kc;
    if (w < 0) deny = !p;
    else if (msup[w] && !p) begin deny = 1; cause = 3; end
    else if (k == 1 && mro[w]) deny = 1;
    else if (k == 2 && mxn[w]) deny = 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        mb[i] = '0; mc[i] = 0; men[i] = 0; mro[i] = 0; mxn[i] = 0; msup[i] = 0;
      end
      mpend = 0; maddr = '0; mcause = 0;
    end else begin
      bit d; int c;
      ref_eval(acc_addr, int'(acc_kind), acc_priv, d, c);
      if (flt_clear) mpend = 0;
      else if (acc_valid && d && !mpend) begin mpend = 1; maddr = acc_addr; mcause = c; end
      if (cfg_we) begin
        mb[cfg_idx] = cfg_base; mc[cfg_idx] = int'(cfg_size); men[cfg_idx] = cfg_en;
        mro[cfg_idx] = cfg_ro; mxn[cfg_idx] = cfg_xn; msup[cfg_idx] = cfg_sup;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && running) begin
      bit d; int c;
      bit ea, ed;
      ref_eval(acc_addr, int'(acc_kind), acc_priv, d, c);
      ea = acc_valid && !d;
      ed = acc_valid && d;
      chk(acc_allow == ea && acc_deny == ed, {cur_req, " verdict"},
          {acc_allow, acc_deny}, {ea, ed});
      chk(flt_pending == mpend, {cur_req, " R10 pending"}, flt_pending, mpend);
      if (mpend)
        chk(flt_addr == maddr && int'(flt_cause) == mcause, {cur_req, " R11 fault record"},
            {flt_addr, flt_cause}, {maddr, 2'(mcause)});
    end
  end

  task automatic cfg(input int idx, input logic [31:0] base, input int code,
                     input bit ro, input bit xn, input bit sup, input bit en);
    @(posedge clk); #1;
    acc_valid = 0; cfg_we = 1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = 5'(code);
    cfg_ro = ro; cfg_xn = xn; cfg_sup = sup; cfg_en = en;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic access(input logic [31:0] a, input int k, input bit p,
                        input bit exp_allow, input string tag);
    @(posedge clk); #1;
    acc_valid = 1; acc_addr = a; acc_kind = 2'(k); acc_priv = p;
    @(negedge clk);
    chk(acc_allow == exp_allow && acc_deny == !exp_allow, tag, acc_allow, exp_allow);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic fault_expect(input bit pend, input logic [31:0] a, input int cause, input string tag);
    @(negedge clk);
    chk(flt_pending == pend, tag, flt_pending, pend);
    if (pend) chk(flt_addr == a && int'(flt_cause) == cause, tag,
                  {flt_addr, flt_cause}, {a, 2'(cause)});
  endtask

  task automatic clear();
    @(posedge clk); #1;
    acc_valid = 0; flt_clear = 1;
    @(posedge clk); #1;
    flt_clear = 0;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(flt_pending == 0 && flt_addr == 0 && flt_cause == 0, "R12 reset fault",
        {flt_pending, flt_addr, flt_cause}, 0);
    running = 1;
    cur_req = "R12";
    access(32'h0000_1234, 0, 1, 1, "R12 no windows priv read");
    cur_req = "R8";
    access(32'h0000_1234, 0, 0, 0, "R8 no match unpriv read");
    idle();
    fault_expect(1, 32'h0000_1234, 0, "R10 capture read");
    cur_req = "R11";
    access(32'h0000_8000, 1, 0, 0, "R8 no match unpriv write");
    idle();
    fault_expect(1, 32'h0000_1234, 0, "R11 sticky record");
    clear();
    fault_expect(0, 0, 0, "R11 cleared");

    cur_req = "R6";
    cfg(0, 32'h2000_0000, 15, 0, 1, 0, 1);
    access(32'h2000_FFFC, 0, 0, 1, "R2 top of 64K window");
    access(32'h2000_0010, 1, 0, 1, "R6 write into no-exec ok");
    access(32'h2000_0100, 2, 0, 0, "R6 fetch into no-exec");
    idle();
    fault_expect(1, 32'h2000_0100, 2, "R6 fetch cause");
    clear();
    cur_req = "R2";
    access(32'h2001_0000, 0, 0, 0, "R2 just past window");
    clear();

    cur_req = "R5";
    cfg(1, 32'h0000_0000, 17, 1, 0, 0, 1);
    access(32'h0003_FFF0, 1, 0, 0, "R5 write into read-only");
    idle();
    fault_expect(1, 32'h0003_FFF0, 1, "R5 write cause");
    clear();
    access(32'h0003_FFF0, 2, 0, 1, "R5 fetch read-only ok");
    access(32'h0000_0004, 0, 0, 1, "R5 read read-only ok");

    cur_req = "R4";
    cfg(5, 32'h2000_8000, 11, 0, 0, 0, 1);
    access(32'h2000_8ABC, 2, 0, 1, "R4 higher window allows fetch");
    access(32'h2000_9000, 2, 0, 0, "R4 outside inner window");
    clear();
    cfg(3, 32'h2000_8000, 11, 1, 1, 0, 1);
    access(32'h2000_8ABC, 1, 0, 1, "R4 lower index loses");

    cur_req = "R7";
    cfg(6, 32'h4000_0000, 4, 1, 1, 1, 1);
    access(32'h4000_001C, 0, 0, 0, "R7 unpriv into supervisor");
    idle();
    fault_expect(1, 32'h4000_001C, 3, "R7 privilege cause");
    clear();
    access(32'h4000_001C, 0, 1, 1, "R7 priv read ok");
    access(32'h4000_001C, 1, 1, 0, "R7 priv write read-only");
    idle();
    fault_expect(1, 32'h4000_001C, 1, "R7 priv follows R5");
    clear();
    access(32'h4000_0020, 0, 1, 1, "R8 priv past 32B window");

    cur_req = "R2";
    cfg(7, 32'h5000_0000, 2, 0, 0, 0, 1);
    access(32'h5000_001F, 0, 0, 1, "R2 small code last byte");
    access(32'h5000_0020, 0, 0, 0, "R2 small code past end");
    clear();

    // R1: write and access in the same cycle
    cur_req = "R1";
    @(posedge clk); #1;
    cfg_we = 1; cfg_idx = 3'd7; cfg_base = 32'h5000_0000; cfg_size = 5'd4;
    cfg_ro = 0; cfg_xn = 0; cfg_sup = 0; cfg_en = 0;
    acc_valid = 1; acc_addr = 32'h5000_0000; acc_kind = 2'd0; acc_priv = 0;
    @(negedge clk);
    chk(acc_allow == 1, "R1 old contents same cycle", acc_allow, 1);
    @(posedge clk); #1;
    cfg_we = 0;
    @(negedge clk);
    chk(acc_deny == 1, "R3 disabled window after write", acc_deny, 1);
    clear();

    cur_req = "R3";
    cfg(0, 32'h2000_0000, 15, 0, 1, 0, 0);
    access(32'h2000_0100, 2, 0, 0, "R3 disabled window no match");
    idle();
    fault_expect(1, 32'h2000_0100, 2, "R8 fetch kind cause");
    clear();

    cur_req = "R11";
    @(posedge clk); #1;
    flt_clear = 1; acc_valid = 1; acc_addr = 32'h7000_0000; acc_kind = 0; acc_priv = 0;
    @(posedge clk); #1;
    flt_clear = 0; acc_valid = 0;
    fault_expect(0, 0, 0, "R11 clear beats deny");

    cur_req = "R2";
    cfg(2, 32'h1234_5678, 31, 0, 0, 0, 1);
    access(32'hF000_0000, 0, 0, 1, "R2 whole-space window");
    access(32'h2000_0100, 2, 0, 1, "R2 whole-space fetch");

    cur_req = "R4 R7 random";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] bases[4];
      bases[0] = 32'h2000_0000; bases[1] = 32'h4000_0000;
      bases[2] = 32'h0000_0000; bases[3] = 32'h5000_0000;
      @(posedge clk); #1;
      cfg_we = ($urandom % 6) == 0;
      cfg_idx = 3'($urandom);
      cfg_base = bases[$urandom % 4] + ($urandom % 32'h8000);
      cfg_size = 5'(($urandom % 3 == 0) ? $urandom : $urandom % 18);
      cfg_ro = 1'($urandom); cfg_xn = 1'($urandom);
      cfg_sup = 1'($urandom); cfg_en = ($urandom % 4) != 0;
      acc_valid = ($urandom % 5) != 0;
      acc_addr = bases[$urandom % 4] + ($urandom % 32'h10000);
      acc_kind = 2'($urandom);
      acc_priv = 1'($urandom);
      flt_clear = ($urandom % 7) == 0;
    end
    @(posedge clk); #1;
    cfg_we = 0; acc_valid = 0; flt_clear = 0;
    @(negedge clk);
    running = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule